// File: doc/BRIEF.md
# PFC Conduction Mode Selector

This block is the timing core of a multimode boost power-factor stage. It times every inductor-current cycle in clock cycles, from the start pulse it issues for the power switch to the zero-current detect pulse. From that duration it decides when the next switching cycle begins and which conduction regime the stage is in.

When the current returns to zero after the minimum period has already elapsed, the next cycle starts at once. This is critical conduction. When the current returns to zero too early, the block waits out the minimum period and then starts on the next valley pulse. This is discontinuous conduction, and it switches in the voltage valley.

The minimum period follows a foldback input, which lengthens it at light load. It is always bounded so that the switching period never exceeds the longest allowed period. If the current has not returned to zero by the longest period, the block forces a restart.

A single very long current cycle moves the block into a fixed-frequency continuous-conduction regime. In that regime start pulses come from the period counter alone. The block leaves that regime only after a number of line-cycle ticks have passed with no long cycle. An overstress flag forces it out of that regime and keeps it out.

Top module: `pfc_mode_sel`

## Requirements
- R1: While not in the continuous regime, a `zcd` pulse whose measured duration d satisfies d >= clamp and d <= CCM_PERIOD*112/100 sets `gate_start` in the next cycle and sets `mode` to 2'b00 (critical). The duration d is the count of clock cycles from the cycle in which `gate_start` was high to the cycle in which `zcd` is high.
- R2: A `zcd` pulse with d < clamp produces no start pulse and sets `mode` to 2'b01 (discontinuous). Any further `zcd` is ignored until the next start.
- R3: In the discontinuous hold, a `valley` pulse seen at duration >= clamp starts the next cycle one clock later. A `valley` pulse seen earlier has no effect.
- R4: The clamp equals `fold_period`, limited to the range CLAMP_MIN..MAX_PERIOD-1 clock cycles. The defaults are 25 and 130.
- R5: Outside the continuous regime, two start pulses are never more than MAX_PERIOD clock cycles apart. With no `zcd` pulse, the next start comes exactly MAX_PERIOD cycles after the previous one.
- R6: A `zcd` pulse with d > CCM_PERIOD*112/100 (56 by default) starts the next cycle at once and sets `mode` to 2'b10 (continuous), unless `ccm_disable` is high.
- R7: In the continuous regime, start pulses come every CCM_PERIOD clock cycles. Pulses on `zcd` and `valley` neither add nor move a start.
- R8: The continuous regime is left, with `mode` set to 2'b00, on the BLANK_TICKS-th `line_tick` counted since entry. A continuous period that ends without a `zcd` pulse restarts that count.
- R9: While `ccm_disable` is high, `mode` is 2'b10 at no clock edge after it. It forces an exit in one cycle and blocks entry; a long cycle is then handled as critical.
- R10: Reset clears `gate_start` and sets `mode` to 2'b00. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| zcd | input | 1 | One-cycle pulse: inductor current reached zero |
| valley | input | 1 | One-cycle pulse: drain voltage valley |
| line_tick | input | 1 | One-cycle pulse once per line cycle |
| fold_period | input | CNT_W | Requested minimum switching period in clock cycles |
| ccm_disable | input | 1 | Overstress flag; forbids the continuous regime |
| gate_start | output | 1 | Registered one-cycle pulse starting a switching cycle |
| mode | output | 2 | Conduction regime: 00 critical, 01 discontinuous, 10 continuous |

## Verification
The assertions take `zcd`, `valley` and `line_tick` to be one-clock pulses that are already synchronous. They also take `fold_period` to change only slowly relative to a switching cycle; the clamp check compares against the registered clamp of the previous cycle. The stimulus drives every pulse for exactly one clock on the falling edge. It changes `fold_period` only in the cycle in which a start pulse has just been seen, and it raises `ccm_disable` as a level held for whole cycles.

// File: rtl/pfc_mode_pkg.sv
package pfc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_CRM = 2'b00,
    MODE_DCM = 2'b01,
    MODE_CCM = 2'b10
  } pfc_mode_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'b00,
    PH_HOLD = 2'b01,
    PH_CCM  = 2'b10
  } pfc_phase_e;

endpackage

// File: rtl/pfc_cycle_timer.sv
module pfc_cycle_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] tcnt
);

  localparam logic [CNT_W-1:0] TOP = '1;

  // Clock cycles since the last start; saturates instead of wrapping.
  always_ff @(posedge clk) begin
    if (rst)
      tcnt <= '0;
    else if (restart)
      tcnt <= '0;
    else if (tcnt != TOP)
      tcnt <= tcnt + 1'b1;
  end

endmodule

// File: rtl/pfc_clamp_calc.sv
module pfc_clamp_calc #(
  parameter int CNT_W      = 10,
  parameter int CLAMP_MIN  = 25,
  parameter int MAX_PERIOD = 130
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fold_period,
  output logic [CNT_W-1:0] clamp_q
);

  localparam logic [CNT_W-1:0] LO = CNT_W'(CLAMP_MIN);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_PERIOD - 1);

  logic [CNT_W-1:0] clamp_n;

  always_comb begin
    if (fold_period < LO)
      clamp_n = LO;
    else if (fold_period > HI)
      clamp_n = HI;
    else
      clamp_n = fold_period;
  end

  always_ff @(posedge clk) begin
    if (rst)
      clamp_q <= LO;
    else
      clamp_q <= clamp_n;
  end

  assert_clamp_range_R4: assert property (@(posedge clk) disable iff (rst)
    (clamp_q >= LO) && (clamp_q <= HI));

endmodule

// File: rtl/pfc_ccm_blank.sv
module pfc_ccm_blank #(
  parameter int BLANK_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic period_end,
  input  logic zcd,
  input  logic line_tick,
  output logic exit_req
);

  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam logic [BW-1:0] LAST = BW'(BLANK_TICKS - 1);

  logic          zcd_seen;
  logic [BW-1:0] bcnt;
  logic          long_now;

  // A continuous period is long when it ends without any zero-current pulse.
  assign long_now = period_end && !(zcd_seen || zcd);
  assign exit_req = active && line_tick && !long_now && (bcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      zcd_seen <= 1'b0;
      bcnt     <= '0;
    end else begin
      if (period_end)
        zcd_seen <= 1'b0;
      else if (zcd)
        zcd_seen <= 1'b1;
      if (long_now)
        bcnt <= '0;
      else if (line_tick && !exit_req)
        bcnt <= bcnt + 1'b1;
    end
  end

  assert_blank_bound_R8: assert property (@(posedge clk) disable iff (rst)
    bcnt <= LAST);

  assert_blank_long_R8: assert property (@(posedge clk) disable iff (rst)
    (active && long_now) |=> (bcnt == '0));

endmodule

// File: rtl/pfc_mode_sel.sv
module pfc_mode_sel
  import pfc_mode_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int CCM_PERIOD  = 50,
  parameter int CLAMP_MIN   = 25,
  parameter int MAX_PERIOD  = 130,
  parameter int BLANK_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zcd,
  input  logic             valley,
  input  logic             line_tick,
  input  logic [CNT_W-1:0] fold_period,
  input  logic             ccm_disable,
  output logic             gate_start,
  output logic [1:0]       mode
);

  localparam int CCM_ENTER = (CCM_PERIOD * 112) / 100;
  localparam logic [CNT_W-1:0] ENTER_C    = CNT_W'(CCM_ENTER);
  localparam logic [CNT_W-1:0] CCM_LAST   = CNT_W'(CCM_PERIOD - 1);
  localparam logic [CNT_W-1:0] TMAX_LAST  = CNT_W'(MAX_PERIOD - 1);
  localparam logic [CNT_W-1:0] TMAX_C     = CNT_W'(MAX_PERIOD);

  logic [CNT_W-1:0] tcnt;
  logic [CNT_W-1:0] clamp_q;
  logic             fire;
  logic             ccm_tick;
  logic             blank_exit;
  pfc_phase_e       phase_q, phase_n;
  pfc_mode_e        mode_q, mode_n;

  pfc_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (fire),
    .tcnt    (tcnt)
  );

  pfc_clamp_calc #(
    .CNT_W      (CNT_W),
    .CLAMP_MIN  (CLAMP_MIN),
    .MAX_PERIOD (MAX_PERIOD)
  ) u_clamp (
    .clk         (clk),
    .rst         (rst),
    .fold_period (fold_period),
    .clamp_q     (clamp_q)
  );

  assign ccm_tick = (phase_q == PH_CCM) && (tcnt >= CCM_LAST);

  pfc_ccm_blank #(.BLANK_TICKS(BLANK_TICKS)) u_blank (
    .clk        (clk),
    .rst        (rst),
    .active     (phase_q == PH_CCM),
    .period_end (ccm_tick),
    .zcd        (zcd),
    .line_tick  (line_tick),
    .exit_req   (blank_exit)
  );

  always_comb begin
    fire    = 1'b0;
    phase_n = phase_q;
    mode_n  = mode_q;
    unique case (phase_q)
      PH_WAIT: begin
        if (zcd) begin
          if ((tcnt > ENTER_C) && !ccm_disable) begin
            fire    = 1'b1;
            phase_n = PH_CCM;
            mode_n  = MODE_CCM;
          end else if (tcnt >= clamp_q) begin
            fire    = 1'b1;
            mode_n  = MODE_CRM;
          end else begin
            phase_n = PH_HOLD;
            mode_n  = MODE_DCM;
          end
        end else if (tcnt >= TMAX_LAST) begin
          fire = 1'b1;
        end
      end
      PH_HOLD: begin
        if ((valley && (tcnt >= clamp_q)) || (tcnt >= TMAX_LAST)) begin
          fire    = 1'b1;
          phase_n = PH_WAIT;
        end
      end
      PH_CCM: begin
        if (ccm_disable || blank_exit) begin
          phase_n = PH_WAIT;
          mode_n  = MODE_CRM;
        end else if (ccm_tick) begin
          fire = 1'b1;
        end
      end
      default: begin
        phase_n = PH_WAIT;
        mode_n  = MODE_CRM;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_WAIT;
      mode_q     <= MODE_CRM;
      gate_start <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      mode_q     <= mode_n;
      gate_start <= fire;
    end
  end

  assign mode = mode_q;

  assert_tmax_R5: assert property (@(posedge clk) disable iff (rst)
    tcnt < TMAX_C);

  assert_dcm_clamp_R2: assert property (@(posedge clk) disable iff (rst)
    (gate_start && (mode_q == MODE_DCM)) |-> ($past(tcnt) >= $past(clamp_q)));

  assert_ccm_period_R7: assert property (@(posedge clk) disable iff (rst)
    (gate_start && ($past(phase_q) == PH_CCM)) |-> ($past(tcnt) == CCM_LAST));

  assert_ccm_off_R9: assert property (@(posedge clk) disable iff (rst)
    ccm_disable |=> (mode_q != MODE_CCM));

  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

endmodule

// File: tb/sim_pfc_mode_sel.sv
module sim_pfc_mode_sel;

  localparam int CNT_W = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             zcd = 1'b0;
  logic             valley = 1'b0;
  logic             line_tick = 1'b0;
  logic [CNT_W-1:0] fold_period = '0;
  logic             ccm_disable = 1'b0;
  logic             gate_start;
  logic [1:0]       mode;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pfc_mode_sel u0 (
    .clk         (clk),
    .rst         (rst),
    .zcd         (zcd),
    .valley      (valley),
    .line_tick   (line_tick),
    .fold_period (fold_period),
    .ccm_disable (ccm_disable),
    .gate_start  (gate_start),
    .mode        (mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_zcd();
    zcd = 1'b1; @(negedge clk); zcd = 1'b0;
  endtask

  task automatic pulse_valley();
    valley = 1'b1; @(negedge clk); valley = 1'b0;
  endtask

  task automatic pulse_tick();
    line_tick = 1'b1; @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic wait_gate(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (gate_start || n > 1000) break;
    end
  endtask

  task automatic sync_gate();
    int n;
    if (!gate_start) wait_gate(n);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R10 gate in reset", int'(gate_start), 0);
    chk("R10 mode in reset", int'(mode), 0);
    rst = 1'b0;
  endtask

  task automatic t_timeout();
    int n;
    sync_gate();
    wait_gate(n);
    chk("R5 period with no zcd", n, 130);
  endtask

  task automatic t_crm(input int d);
    sync_gate();
    repeat (d) @(negedge clk);
    pulse_zcd();
    chk("R1 immediate start", int'(gate_start), 1);
    chk("R1 mode critical", int'(mode), 0);
  endtask

  task automatic t_dcm();
    sync_gate();
    repeat (10) @(negedge clk);
    pulse_zcd();
    chk("R2 no start before clamp", int'(gate_start), 0);
    chk("R2 mode discontinuous", int'(mode), 1);
    repeat (13) @(negedge clk);
    pulse_valley();
    chk("R3 early valley ignored", int'(gate_start), 0);
    pulse_valley();
    chk("R3 valley at clamp starts", int'(gate_start), 1);
    chk("R3 mode stays discontinuous", int'(mode), 1);
  endtask

  task automatic t_fold();
    int n;
    fold_period = 10'd60;
    sync_gate();
    repeat (40) @(negedge clk);
    pulse_zcd();
    chk("R4 fold 60 holds", int'(mode), 1);
    repeat (18) @(negedge clk);
    pulse_valley();
    chk("R4 valley at 59 ignored", int'(gate_start), 0);
    pulse_valley();
    chk("R4 valley at 60 starts", int'(gate_start), 1);
    fold_period = 10'd500;
    repeat (40) @(negedge clk);
    pulse_zcd();
    repeat (59) @(negedge clk);
    pulse_valley();
    chk("R4 valley at 100 under large fold ignored", int'(gate_start), 0);
    wait_gate(n);
    chk("R4 large fold bounded by max period", n, 29);
    fold_period = 10'd5;
    repeat (10) @(negedge clk);
    pulse_zcd();
    repeat (14) @(negedge clk);
    pulse_valley();
    chk("R4 small fold floors at minimum", int'(gate_start), 1);
    fold_period = '0;
  endtask

  task automatic t_enter(input bit dis, input int exp_mode, input string req);
    sync_gate();
    ccm_disable = dis;
    repeat (57) @(negedge clk);
    pulse_zcd();
    chk({req, " start on long cycle"}, int'(gate_start), 1);
    chk({req, " mode after long cycle"}, int'(mode), exp_mode);
    ccm_disable = 1'b0;
  endtask

  task automatic ccm_period(input bit give_zcd, input bit give_tick, input int exp_mode);
    int n;
    sync_gate();
    repeat (10) @(negedge clk);
    if (give_zcd) pulse_zcd(); else @(negedge clk);
    chk("R7 zcd adds no start", int'(gate_start), 0);
    repeat (5) @(negedge clk);
    pulse_valley();
    chk("R7 valley adds no start", int'(gate_start), 0);
    repeat (13) @(negedge clk);
    if (give_tick) pulse_tick(); else @(negedge clk);
    chk("R8 mode after line tick", int'(mode), exp_mode);
    if (exp_mode == 2) begin
      wait_gate(n);
      chk("R7 continuous period", n, 19);
    end
  endtask

  task automatic t_ccm_blank();
    int n;
    t_enter(1'b0, 2, "R6");
    wait_gate(n);
    chk("R7 first continuous period", n, 50);
    for (int i = 0; i < 3; i++) ccm_period(1'b1, 1'b1, 2);
    ccm_period(1'b0, 1'b0, 2);
    for (int i = 0; i < 3; i++) ccm_period(1'b1, 1'b1, 2);
    ccm_period(1'b1, 1'b1, 0);
  endtask

  task automatic t_disable();
    t_enter(1'b0, 2, "R9 re-entry");
    repeat (5) @(negedge clk);
    ccm_disable = 1'b1;
    @(negedge clk);
    chk("R9 forced exit", int'(mode), 0);
    ccm_disable = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_timeout();
    t_crm(40);
    t_crm(56);
    t_crm(25);
    t_dcm();
    t_fold();
    t_enter(1'b1, 0, "R9 blocked");
    t_ccm_blank();
    t_timeout();
    t_disable();
    t_timeout();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule